// File: doc/BRIEF.md
# Controller Role Request Sequencer

A standby I3C controller that wants to take over the bus asks the current active controller with an in-band interrupt (IBI). This block runs that request on behalf of software. A write of 1 to the request-send control bit starts a request, but only when the device can make simple requests. The block then waits until the bus is available. It raises a request toward the IBI serializer and holds it until the serializer reports that the IBI went out. After that it records the answer of the active controller in a 3-bit status field.

There are three possible answers. An acknowledge means ownership will be handed over. A plain not-acknowledge means the request may be retried later. A not-acknowledge followed, before the next STOP, by a disable-events command with the controller-role bit set means further requests are refused. Each final answer raises a one-cycle response interrupt. The IBI serializer, the bus-condition timers and the decoding of bus responses sit outside this block. They reach it as single-cycle strobes.

Top module: `crr_sequencer`

## Requirements
- R1: While reset is low and in the first cycle after it is released, the status reads 3'b000 (idle), ibi_start_req is 0 and resp_irq is 0.
- R2: A cycle with req_send_wr=1, simple_crr_cap=1 and a status other than 3'b001 sets the status to 3'b001 (pending) from the next clock edge. This applies from idle (3'b000) and from each outcome value (3'b010, 3'b011, 3'b100).
- R3: While the status is 3'b001, req_send_wr has no effect: the status, ibi_start_req and the response phase already reached are all unchanged.
- R4: With simple_crr_cap=0, req_send_wr has no effect and the status keeps its value, whether that value is idle or an earlier outcome.
- R5: ibi_start_req rises only on the clock edge after a cycle in which bus_avail=1 was seen while pending. It stays high until a cycle with ibi_sent=1 and is low from the following edge.
- R6: After the IBI has been sent, a cycle with resp_ack=1 sets the status to 3'b100 (ownership will be transferred).
- R7: After the IBI has been sent, resp_nack=1 followed by bus_stop=1 with no disable command in between sets the status to 3'b010 (retry allowed) at the STOP.
- R8: After the IBI has been sent, resp_nack=1 followed, before or in the same cycle as the next STOP, by resp_disec_cr=1 sets the status to 3'b011 (requests disabled). A disable command that arrives after that STOP changes nothing.
- R9: resp_irq is high for exactly the one cycle in which the status first shows 3'b010, 3'b011 or 3'b100, and is low otherwise. The move to 3'b001 raises no interrupt.
- R10: resp_ack, resp_nack and resp_disec_cr have no effect before the IBI has been sent or while no request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_send_wr | input | 1 | Strobe: software wrote 1 to the request-send bit |
| simple_crr_cap | input | 1 | Capability: simple controller-role requests are supported |
| bus_avail | input | 1 | Bus Available condition detected |
| ibi_sent | input | 1 | Handshake from the IBI serializer: request IBI transmitted |
| resp_ack | input | 1 | Active controller acknowledged the request |
| resp_nack | input | 1 | Active controller refused the request |
| resp_disec_cr | input | 1 | Disable-events command with the controller-role bit set was received |
| bus_stop | input | 1 | STOP condition detected |
| crr_status | output | 3 | Request status: 000 idle, 001 pending, 010 retry, 011 disabled, 100 granted |
| ibi_start_req | output | 1 | Request to the serializer to start the controller-role IBI |
| resp_irq | output | 1 | One-cycle response interrupt on a final outcome |

## Verification
On every cycle, the assertions check these rules: a write accepted from a non-pending state leads to pending; without the capability a settled status cannot move; the IBI request is only raised when pending and only after a bus-available cycle; and the interrupt fires exactly when pending gives way to an outcome. Only the bench scenarios can show the rest. These are which outcome each response sequence produces, that a disable command after the STOP is too late, that responses are ignored before the IBI goes out, and that a write during pending leaves the phase reached so far intact.

// File: rtl/crr_pkg.sv
// Shared encodings for the controller role request sequencer.
// Assumes: status values are fixed by the register definition and
// must not be renumbered.
package crr_pkg;

    localparam int STATUS_W = 3;

    typedef enum logic [STATUS_W-1:0] {
        ST_IDLE     = 3'b000,
        ST_PEND     = 3'b001,
        ST_RETRY    = 3'b010,
        ST_DISABLED = 3'b011,
        ST_GRANTED  = 3'b100
    } crr_stat_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT_BUS,
        PH_REQ_IBI,
        PH_WAIT_RESP,
        PH_WAIT_DISEC
    } crr_phase_e;

endpackage

// File: rtl/crr_req_gate.sv
// Decides whether a software write starts a new request.
// Assumes: req_send_wr is a one-cycle strobe for a write of 1.
module crr_req_gate
    import crr_pkg::*;
(
    input  logic                req_send_wr,
    input  logic                simple_crr_cap,
    input  logic [STATUS_W-1:0] cur_status,
    output logic                accept
);

    // Accept only with the capability set and no request already pending.
    always_comb begin
        accept = req_send_wr && simple_crr_cap && (cur_status != ST_PEND);
    end

endmodule

// File: rtl/crr_phase_fsm.sv
// Sequences one request: wait for bus available, drive the IBI request
// until sent, then classify the active controller's response.
// Assumes: response and bus-condition inputs are single-cycle strobes.
module crr_phase_fsm
    import crr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                bus_avail,
    input  logic                ibi_sent,
    input  logic                resp_ack,
    input  logic                resp_nack,
    input  logic                resp_disec_cr,
    input  logic                bus_stop,
    output logic                ibi_start_req,
    output logic                outcome_vld,
    output logic [STATUS_W-1:0] outcome_code
);

    crr_phase_e phase_q, phase_d;

    // Next-phase and outcome decode.
    always_comb begin
        phase_d      = phase_q;
        outcome_vld  = 1'b0;
        outcome_code = ST_IDLE;
        unique case (phase_q)
            PH_IDLE:      if (start) phase_d = PH_WAIT_BUS;
            PH_WAIT_BUS:  if (bus_avail) phase_d = PH_REQ_IBI;
            PH_REQ_IBI:   if (ibi_sent) phase_d = PH_WAIT_RESP;
            PH_WAIT_RESP: begin
                if (resp_ack) begin
                    phase_d      = PH_IDLE;
                    outcome_vld  = 1'b1;
                    outcome_code = ST_GRANTED;
                end else if (resp_nack) begin
                    phase_d = PH_WAIT_DISEC;
                end
            end
            PH_WAIT_DISEC: begin
                if (resp_disec_cr) begin
                    phase_d      = PH_IDLE;
                    outcome_vld  = 1'b1;
                    outcome_code = ST_DISABLED;
                end else if (bus_stop) begin
                    phase_d      = PH_IDLE;
                    outcome_vld  = 1'b1;
                    outcome_code = ST_RETRY;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // IBI request is held for the whole request phase.
    always_comb begin
        ibi_start_req = (phase_q == PH_REQ_IBI);
    end

endmodule

// File: rtl/crr_status_reg.sv
// Holds the 3-bit request status and pulses the response interrupt
// when a final outcome is written.
// Assumes: accept and outcome_vld are never high in the same cycle.
module crr_status_reg
    import crr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                outcome_vld,
    input  logic [STATUS_W-1:0] outcome_code,
    output logic [STATUS_W-1:0] status,
    output logic                irq
);

    // Status update: pending on accept, outcome on response.
    always_ff @(posedge clk) begin
        if (!rst_n)           status <= ST_IDLE;
        else if (outcome_vld) status <= outcome_code;
        else if (accept)      status <= ST_PEND;
    end

    // Interrupt pulse in the cycle the outcome becomes visible.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= outcome_vld;
    end

endmodule

// File: rtl/crr_sequencer.sv
// Top of the controller role request sequencer: joins the write gate,
// the phase machine and the status register.
// Assumes: all inputs are synchronous to clk.
module crr_sequencer
    import crr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_send_wr,
    input  logic                simple_crr_cap,
    input  logic                bus_avail,
    input  logic                ibi_sent,
    input  logic                resp_ack,
    input  logic                resp_nack,
    input  logic                resp_disec_cr,
    input  logic                bus_stop,
    output logic [STATUS_W-1:0] crr_status,
    output logic                ibi_start_req,
    output logic                resp_irq
);

    logic                accept;
    logic                outcome_vld;
    logic [STATUS_W-1:0] outcome_code;

    crr_req_gate u_gate (
        .req_send_wr    (req_send_wr),
        .simple_crr_cap (simple_crr_cap),
        .cur_status     (crr_status),
        .accept         (accept)
    );

    crr_phase_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (accept),
        .bus_avail     (bus_avail),
        .ibi_sent      (ibi_sent),
        .resp_ack      (resp_ack),
        .resp_nack     (resp_nack),
        .resp_disec_cr (resp_disec_cr),
        .bus_stop      (bus_stop),
        .ibi_start_req (ibi_start_req),
        .outcome_vld   (outcome_vld),
        .outcome_code  (outcome_code)
    );

    crr_status_reg u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .outcome_vld  (outcome_vld),
        .outcome_code (outcome_code),
        .status       (crr_status),
        .irq          (resp_irq)
    );

endmodule

// File: rtl/crr_sequencer_chk.sv
// Port-level checker for crr_sequencer, bound to every instance.
module crr_sequencer_chk
    import crr_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req_send_wr,
    input logic                simple_crr_cap,
    input logic                bus_avail,
    input logic                ibi_sent,
    input logic                resp_ack,
    input logic                resp_nack,
    input logic                resp_disec_cr,
    input logic                bus_stop,
    input logic [STATUS_W-1:0] crr_status,
    input logic                ibi_start_req,
    input logic                resp_irq
);

    // R2: accepted write leads to pending.
    a_r2_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (req_send_wr && simple_crr_cap && crr_status != ST_PEND) |=> crr_status == ST_PEND);

    // R4: without capability a settled status does not move.
    a_r4_nocap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!simple_crr_cap && crr_status != ST_PEND) |=> $stable(crr_status));

    // R5: IBI request only while pending.
    a_r5_req_when_pend: assert property (@(posedge clk) disable iff (!rst_n)
        ibi_start_req |-> crr_status == ST_PEND);

    // R5: IBI request rises only after a bus-available cycle.
    a_r5_rise_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibi_start_req) |-> $past(bus_avail));

    // R9: interrupt only with a freshly written outcome.
    a_r9_irq_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        resp_irq |-> (crr_status inside {ST_RETRY, ST_DISABLED, ST_GRANTED})
                     && $past(crr_status) == ST_PEND);

    // R9: leaving pending for an outcome always interrupts.
    a_r9_outcome_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(crr_status) == ST_PEND && crr_status != ST_PEND) |-> resp_irq);

endmodule

bind crr_sequencer crr_sequencer_chk u_chk (.*);

// File: tb/crr_sequencer_tb.sv
module crr_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_send_wr = 0, simple_crr_cap = 0, bus_avail = 0, ibi_sent = 0;
    logic       resp_ack = 0, resp_nack = 0, resp_disec_cr = 0, bus_stop = 0;
    logic [2:0] crr_status;
    logic       ibi_start_req, resp_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [2:0] st;
        logic       start;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    crr_sequencer u_dut (.*);

    // Driver: apply one cycle of stimulus and queue the expected result after the edge.
    task automatic step(input logic wr, cap, ba, sent, ack, nack, dis, stp,
                        input logic [2:0] es, input logic est, eirq, input string tag);
        exp_t e;
        @(negedge clk);
        req_send_wr = wr; simple_crr_cap = cap; bus_avail = ba; ibi_sent = sent;
        resp_ack = ack; resp_nack = nack; resp_disec_cr = dis; bus_stop = stp;
        e.st = es; e.start = est; e.irq = eirq; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare outputs shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (crr_status !== e.st || ibi_start_req !== e.start || resp_irq !== e.irq) begin
                errors++;
                $display("FAIL %s: got st=%b start=%b irq=%b, expected st=%b start=%b irq=%b",
                         e.tag, crr_status, ibi_start_req, resp_irq, e.st, e.start, e.irq);
            end
        end
    end

    initial begin
        // R1 reset state
        step(0,1,0,0,0,0,0,0, 3'b000,0,0, "R1 in reset");
        step(0,1,0,0,0,0,0,0, 3'b000,0,0, "R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        step(0,1,0,0,0,0,0,0, 3'b000,0,0, "R1 after reset");
        step(1,0,0,0,0,0,0,0, 3'b000,0,0, "R4 no cap from idle");
        step(0,1,0,0,1,0,0,0, 3'b000,0,0, "R10 ack while idle");
        step(1,1,0,0,0,0,0,0, 3'b001,0,0, "R2 start from idle");
        step(0,1,0,0,1,0,0,0, 3'b001,0,0, "R10 ack before bus available");
        step(0,1,1,0,0,0,0,0, 3'b001,1,0, "R5 request after bus available");
        step(1,1,0,0,0,0,0,0, 3'b001,1,0, "R3 write while pending");
        step(0,1,0,0,1,0,0,0, 3'b001,1,0, "R10 ack before sent");
        step(0,1,0,1,0,0,0,0, 3'b001,0,0, "R5 drop after sent");
        step(0,1,0,0,1,0,0,0, 3'b100,0,1, "R6 ack granted");
        step(0,1,0,0,0,0,0,0, 3'b100,0,0, "R9 irq one cycle");
        step(1,0,0,0,0,0,0,0, 3'b100,0,0, "R4 no cap keeps outcome");
        // NACK then STOP
        step(1,1,0,0,0,0,0,0, 3'b001,0,0, "R2 start from granted");
        step(0,1,1,0,0,0,0,0, 3'b001,1,0, "R5 request");
        step(0,1,0,1,0,0,0,0, 3'b001,0,0, "R5 sent");
        step(1,1,0,0,0,0,0,0, 3'b001,0,0, "R3 write while waiting response");
        step(0,1,0,0,0,1,0,0, 3'b001,0,0, "R7 nack pending");
        step(0,1,0,0,0,0,0,0, 3'b001,0,0, "R7 waiting stop");
        step(0,1,0,0,0,0,0,1, 3'b010,0,1, "R7 retry on stop");
        step(0,1,0,0,0,0,1,0, 3'b010,0,0, "R8 late disable ignored");
        // NACK then DISEC
        step(1,1,0,0,0,0,0,0, 3'b001,0,0, "R2 start from retry");
        step(0,1,1,0,0,0,0,0, 3'b001,1,0, "R5 request");
        step(0,1,0,1,0,0,0,0, 3'b001,0,0, "R5 sent");
        step(0,1,0,0,0,0,1,0, 3'b001,0,0, "R10 disable before nack");
        step(0,1,0,0,0,1,0,0, 3'b001,0,0, "R8 nack");
        step(0,1,0,0,0,0,1,0, 3'b011,0,1, "R8 disabled");
        step(0,1,0,0,0,0,0,0, 3'b011,0,0, "R9 irq one cycle");
        // DISEC and STOP together
        step(1,1,0,0,0,0,0,0, 3'b001,0,0, "R2 start from disabled");
        step(0,1,1,0,0,0,0,0, 3'b001,1,0, "R5 request");
        step(0,1,0,1,0,0,0,0, 3'b001,0,0, "R5 sent");
        step(0,1,0,0,0,1,0,0, 3'b001,0,0, "R8 nack");
        step(0,1,0,0,0,0,1,1, 3'b011,0,1, "R8 disable with stop");
        step(0,1,0,0,0,0,0,0, 3'b011,0,0, "R9 idle after");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule